// File: doc/BRIEF.md
# Envelope Shape Generator

The block produces one 4-bit amplitude envelope that every sound channel can share. A fixed divide-by-256 prescaler and a programmable 16-bit period counter together pace the envelope. Every `256 * period` clock cycles the level takes one step along a 16-step ramp. A period of zero runs at the same rate as a period of one.

Four shape flags choose how the ramp behaves. Attack sets the starting direction. Continue decides whether the pattern goes on after the first ramp. Alternate reverses the direction at the end of each ramp. Hold freezes the level once the first ramp is done. A one-cycle restart pulse, raised when software writes the shape, captures the flags and restarts the envelope from its first step. Channel mixing and digital-to-analog conversion are not part of this block.

Top module: `env_shape_gen`

## Requirements
- R1: After reset `env_o` is 0, and it stays 0 until the first restart pulse, whatever `period_i` and `shape_i` are.
- R2: After the edge that samples `restart_i`, step n (n ≥ 1) takes effect exactly `256 * P * n` clock edges later, where P is `period_i`. Between steps the output does not change.
- R3: A `period_i` of 0 paces the steps as if `period_i` were 1.
- R4: The shape flags are attack = `shape_i[2]`, continue = `shape_i[3]`, alternate = `shape_i[1]` and hold = `shape_i[0]`. With attack=1 the first ramp reads 0,1,…,15, one value per step. With attack=0 it reads 15,14,…,0.
- R5: With continue=0, the output is 0 from step 16 onward, whatever alternate and hold are.
- R6: With continue=1, alternate=0 and hold=0, the ramp repeats with the same direction: a sawtooth with period 16 steps.
- R7: With continue=1, alternate=1 and hold=0, the direction reverses after every 16 steps. This gives a triangle in which the end value repeats once at each turn.
- R8: With continue=1 and hold=1, the level is frozen from step 16 onward. It holds the first ramp's final value (15 for attack=1, 0 for attack=0), or the complement of that value when alternate=1.
- R9: A restart pulse in the middle of a pattern sets the output to the first ramp value of the new shape (0 for attack=1, 15 for attack=0) on the next edge. It also restarts both the prescaler and the period count.
- R10: The shape is captured only when `restart_i` is high. A change on `shape_i` without a restart has no effect on `env_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | 16 | Envelope period, in units of 256 clocks |
| shape_i | input | 4 | Shape flags {continue, attack, alternate, hold} |
| restart_i | input | 1 | One-cycle pulse on a shape write |
| env_o | output | 4 | Envelope level |

## Verification
The assertions assume that `restart_i` is a single-cycle pulse and that `shape_i` is valid in the cycle the pulse is high. They also assume `period_i` does not change while a pattern is being checked, so that every level change can be traced to a step or a restart. The stimulus raises `restart_i` for exactly one clock. It loads `shape_i` in that same cycle and changes the shape afterwards only in the case that checks R10. It keeps `period_i` fixed during each case and changes it only between restarts.

// File: rtl/env_pkg.sv
package env_pkg;
  // field order matches shape_i[3:0]
  typedef struct packed {
    logic cont;
    logic attack;
    logic alt;
    logic hold;
  } env_shape_t;

  localparam int unsigned SHAPE_W = 4;
endpackage

// File: rtl/env_prescale.sv
module env_prescale #(
  parameter int unsigned DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/env_period.sv
module env_period #(
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [PW-1:0] period_i,
  output logic          step_o
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last_w;

  // zero period behaves as one
  assign last_w = (period_i == '0) ? '0 : period_i - 1'b1;
  assign step_o = tick_i && (cnt_q >= last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/env_ramp.sv
module env_ramp
  import env_pkg::*;
#(
  parameter int unsigned LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  env_shape_t    shape_i,
  input  logic          step_i,
  output logic [LW-1:0] level_o,
  output logic          held_o
);
  localparam logic [LW-1:0] TOP = {LW{1'b1}};

  env_shape_t    shp_q;
  logic [LW-1:0] idx_q;
  logic          up_q;
  logic          held_q;
  logic [LW-1:0] hval_q;
  logic [LW-1:0] end_w;

  assign end_w   = up_q ? TOP : '0;
  assign level_o = held_q ? hval_q : (up_q ? idx_q : ~idx_q);
  assign held_o  = held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shp_q  <= '0;
      idx_q  <= '0;
      up_q   <= 1'b0;
      held_q <= 1'b1;
      hval_q <= '0;
    end else if (restart_i) begin
      shp_q  <= shape_i;
      idx_q  <= '0;
      up_q   <= shape_i.attack;
      held_q <= 1'b0;
    end else if (step_i && !held_q) begin
      if (idx_q == TOP) begin
        if (!shp_q.cont) begin
          held_q <= 1'b1;
          hval_q <= '0;
        end else if (shp_q.hold) begin
          held_q <= 1'b1;
          hval_q <= shp_q.alt ? ~end_w : end_w;
        end else begin
          idx_q <= '0;
          if (shp_q.alt) up_q <= ~up_q;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/env_shape_gen.sv
module env_shape_gen
  import env_pkg::*;
#(
  parameter int unsigned PRESCALE = 256,
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned LVL_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [SHAPE_W-1:0]  shape_i,
  input  logic                restart_i,
  output logic [LVL_W-1:0]    env_o
);
  logic tick_w;
  logic step_w;
  logic held_w;

  env_prescale #(.DIV(PRESCALE)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart_i),
    .tick_o (tick_w)
  );

  env_period #(.PW(PERIOD_W)) i_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart_i),
    .tick_i   (tick_w),
    .period_i (period_i),
    .step_o   (step_w)
  );

  env_ramp #(.LW(LVL_W)) i_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .shape_i   (env_shape_t'(shape_i)),
    .step_i    (step_w),
    .level_o   (env_o),
    .held_o    (held_w)
  );
endmodule

// File: rtl/env_shape_chk.sv
module env_shape_chk #(
  parameter int unsigned LW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          restart_i,
  input logic [3:0]    shape_i,
  input logic [LW-1:0] env_o,
  input logic          step_i,
  input logic          held_i
);
  localparam logic [LW-1:0] ONE = LW'(1);
  localparam logic [LW-1:0] TOP = {LW{1'b1}};

  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        started_q <= 1'b0;
    else if (restart_i) started_q <= 1'b1;
  end

  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> env_o == '0);

  p_step_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (env_o != $past(env_o)) |-> ($past(step_i) || $past(restart_i)));

  p_unit_delta_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (env_o != $past(env_o) && !$past(restart_i))
      |-> (LW'(env_o - $past(env_o)) == ONE || LW'(env_o - $past(env_o)) == TOP));

  p_held_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_i && !restart_i) |=> $stable(env_o));

  p_restart_init_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> env_o == ($past(shape_i[2]) ? '0 : TOP));
endmodule

bind env_shape_gen env_shape_chk #(.LW(LVL_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .restart_i (restart_i),
  .shape_i   (shape_i),
  .env_o     (env_o),
  .step_i    (step_w),
  .held_i    (held_w)
);

// File: tb/test_env_shape_gen.sv
module test_env_shape_gen;
  localparam int PRE = 256;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] period_i = 16'd1;
  logic [3:0]  shape_i = 4'h0;
  logic        restart_i = 1'b0;
  logic [3:0]  env_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int       due;
    logic [3:0] val;
    string    req;
  } item_t;
  item_t sb_q[$];

  env_shape_gen i_env_shape_gen (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .period_i  (period_i),
    .shape_i   (shape_i),
    .restart_i (restart_i),
    .env_o     (env_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] exp_lvl(logic [3:0] s, int n);
    int pos, c;
    bit up;
    if (n < 16) return s[2] ? 4'(n) : 4'(15 - n);
    if (!s[3]) return 4'h0;
    if (s[0]) return (s[1] ^ s[2]) ? 4'hF : 4'h0;
    c   = n / 16;
    pos = n % 16;
    up  = s[2] ^ (s[1] && (c % 2 == 1));
    return up ? 4'(pos) : 4'(15 - pos);
  endfunction

  // monitor: pop and compare when due
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0 && cyc >= sb_q[0].due) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (env_o !== it.val) begin
          bad++;
          $display("FAIL %s: cyc=%0d env_o=%0d expected=%0d", it.req, cyc, env_o, it.val);
        end
      end
    end
  end

  task automatic push(int due, logic [3:0] v, string req);
    item_t it;
    it.due = due; it.val = v; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  // restart with shape s, expect nsteps steps; optional late shape change (R10)
  task automatic run_case(logic [3:0] s, logic [15:0] p, int nsteps, string req,
                          bit chg = 1'b0, logic [3:0] s2 = 4'h0);
    int c0, peff, span;
    @(negedge clk);
    period_i  = p;
    shape_i   = s;
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    c0   = cyc;
    peff = (p == 0) ? 1 : int'(p);
    span = PRE * peff;
    for (int n = 0; n < nsteps; n++) begin
      push(c0 + span * n, exp_lvl(s, n), req);
      push(c0 + span * (n + 1) - 1, exp_lvl(s, n), req);
    end
    if (chg) begin
      @(negedge clk);
      shape_i = s2;
    end
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: cyc=%0d expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    shape_i = 4'hD;
    period_i = 16'd1;
    // R1: idle at zero without restart
    push(cyc + 1, 4'h0, "R1");
    push(cyc + 300, 4'h0, "R1");
    push(cyc + 700, 4'h0, "R1");
    drain();

    run_case(4'b0000, 16'd1, 20, "R5");
    run_case(4'b0100, 16'd2, 20, "R5");
    run_case(4'b0111, 16'd1, 18, "R5");
    run_case(4'b1000, 16'd1, 34, "R6");
    run_case(4'b1100, 16'd1, 34, "R6");
    run_case(4'b1110, 16'd1, 34, "R7");
    run_case(4'b1010, 16'd1, 34, "R7");
    run_case(4'b1001, 16'd1, 20, "R8");
    run_case(4'b1011, 16'd1, 20, "R8");
    run_case(4'b1101, 16'd1, 20, "R8");
    run_case(4'b1111, 16'd1, 20, "R8");
    run_case(4'b1100, 16'd0, 6, "R3");
    run_case(4'b1110, 16'd3, 5, "R2");
    run_case(4'b1101, 16'd1, 5, "R4");
    // mid-ramp restart straight after previous case
    run_case(4'b1000, 16'd1, 6, "R9");
    run_case(4'b1000, 16'd1, 20, "R10", 1'b1, 4'b0111);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule